// File: doc/BRIEF.md
# Looping Waveform Buffer Sequencer

This block walks through a segment of a sample memory and feeds one analog output channel. The segment is set by a start address and a sample count. Each tick of the shared update clock reads one sample, and the segment can be replayed a programmed number of times. Four run modes decide how a trigger is used:

- Single-step mode moves one sample per trigger.
- Burst and waveform modes play a fixed number of passes and then stop on the last sample.
- Continuous mode loops until the block is disabled.

The memory is external to the block and has one cycle of read latency. The block issues a read address with a read strobe, and the returned word leaves the block with a valid strobe in the same cycle as it arrives. `busy` and `done` report the run state.

Top module: `loop_wave_seq`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `memRdEn` and `sampleValid` are all low.
- R2: In burst mode (`mode`=1) or waveform mode (`mode`=2), a trigger accepted while idle plays the addresses `startAddr`, `startAddr`+1, ... through `segLen` samples. The segment is repeated `repeatCnt` times, one sample per update tick.
- R3: A `repeatCnt` of 0 plays one pass. A `segLen` of 0 plays one sample. A `segLen` above 8192 plays 8192 samples.
- R4: Sample addresses are 13 bits wide and wrap modulo 8192 past the top of the buffer.
- R5: `memRdEn` is high only in a cycle where `tick` is high, and the block issues at most one read per tick. `sampleValid` is high in the cycle after each read, and in that cycle `sampleOut` equals `memData`.
- R6: When a finite run ends, `busy` falls and `done` rises. `sampleOut` then keeps the last sample. The next accepted trigger clears `done`.
- R7: In burst or waveform mode, a trigger that arrives while busy has no effect on the sample sequence.
- R8: In continuous mode (`mode`=3), the segment repeats without end and `repeatCnt` is ignored. `done` never rises in this mode.
- R9: In single-step mode (`mode`=0), each trigger produces exactly one sample on the next tick, and the steps wrap within the segment. `busy` stays high until the block is disabled.
- R10: When `enable` is low, the block goes idle at the next edge with `done` cleared, issues no reads and ignores triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low forces idle |
| mode | input | 2 | 0 single-step, 1 burst, 2 waveform, 3 continuous |
| startAddr | input | 13 | First sample address of the segment |
| segLen | input | 14 | Samples per pass |
| repeatCnt | input | 16 | Number of passes for burst/waveform |
| trigIn | input | 1 | Single-cycle trigger pulse |
| tick | input | 1 | Update-clock tick, one cycle wide |
| memAddr | output | 13 | Sample memory read address |
| memRdEn | output | 1 | Sample memory read strobe |
| memData | input | 16 | Sample memory read data, one cycle after the read |
| sampleOut | output | 16 | Output sample; holds the last value between reads |
| sampleValid | output | 1 | `sampleOut` carries a fresh sample |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A finite run has completed |

## Verification
A trigger is sampled at one edge, and `busy` is visible after that edge. The first read goes out at the next edge where `tick` is high. Its sample shows on `sampleOut` with `sampleValid` in the cycle after that read, and `done` rises together with the valid of the final sample.

The bench drives every input on the falling edge. The monitor compares each valid sample on the falling edge against a queue of addresses the driver has worked out in advance. Any sample that arrives after the queue is empty counts as a failure. The status checks wait for `done`, or let whole tick periods pass, before they sample.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  typedef enum logic [1:0] {
    MODE_STEP  = 2'd0,
    MODE_BURST = 2'd1,
    MODE_WAVE  = 2'd2,
    MODE_CONT  = 2'd3
  } seqMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch segment config, rewind offset
    logic issue;  // read current address and advance
  } dpCtrl_t;

endpackage

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [REP_W-1:0] repeatCnt,
  input  logic             trigIn,
  input  logic             tick,
  input  logic             segEnd,
  output dpCtrl_t          ctrl,
  output logic             busy,
  output logic             done
);

  localparam logic [REP_W-1:0] ONE_PASS = REP_W'(1);

  logic             busyQ, doneQ, stepPendQ;
  seqMode_e         modeQ;
  logic [REP_W-1:0] loopLeftQ;

  logic isFinite, startRun, stepTrig, issue, lastPass, passEnd, finish;

  always_comb begin
    isFinite = (modeQ == MODE_BURST) || (modeQ == MODE_WAVE);
    startRun = enable && trigIn && !busyQ;
    stepTrig = enable && trigIn && busyQ && (modeQ == MODE_STEP);
    issue    = enable && busyQ && tick && ((modeQ != MODE_STEP) || stepPendQ);
    lastPass = (loopLeftQ == ONE_PASS);
    passEnd  = issue && segEnd && isFinite;
    finish   = passEnd && lastPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      stepPendQ <= 1'b0;
      modeQ     <= MODE_STEP;
      loopLeftQ <= ONE_PASS;
    end else if (!enable) begin
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      stepPendQ <= 1'b0;
    end else if (startRun) begin
      busyQ     <= 1'b1;
      doneQ     <= 1'b0;
      modeQ     <= seqMode_e'(mode);
      loopLeftQ <= (repeatCnt == '0) ? ONE_PASS : repeatCnt;
      stepPendQ <= (seqMode_e'(mode) == MODE_STEP);
    end else begin
      if (finish) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else if (passEnd) begin
        loopLeftQ <= loopLeftQ - ONE_PASS;
      end
      if (stepTrig)   stepPendQ <= 1'b1;
      else if (issue) stepPendQ <= 1'b0;
    end
  end

  always_comb begin
    ctrl.load  = startRun;
    ctrl.issue = issue;
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R5
  read_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issue |-> tick);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyQ && doneQ));

  // R8
  cont_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && modeQ == MODE_CONT) |=> !doneQ);

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busyQ && !doneQ));

  // R2
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(ctrl.issue));

endmodule

// File: rtl/wseq_dp.sv
module wseq_dp
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              segEnd,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid
);

  localparam int              DEPTH     = 1 << ADDR_W;
  localparam logic [LEN_W-1:0] DEPTH_LEN = LEN_W'(DEPTH);

  logic [ADDR_W-1:0] startQ, lenM1Q, offQ, lenM1Next;
  logic              rdPendQ;
  logic [DATA_W-1:0] heldQ;

  // clamp the requested length to 1..DEPTH and store it minus one
  always_comb begin
    if (segLen == '0)            lenM1Next = '0;
    else if (segLen > DEPTH_LEN) lenM1Next = ADDR_W'(DEPTH - 1);
    else                         lenM1Next = ADDR_W'(segLen - LEN_W'(1));
  end

  assign segEnd  = (offQ == lenM1Q);
  assign memAddr = startQ + offQ;  // natural modulo-DEPTH wrap
  assign memRdEn = ctrl.issue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= '0;
      lenM1Q  <= '0;
      offQ    <= '0;
      rdPendQ <= 1'b0;
      heldQ   <= '0;
    end else begin
      rdPendQ <= ctrl.issue;
      if (rdPendQ) heldQ <= memData;
      if (ctrl.load) begin
        startQ <= startAddr;
        lenM1Q <= lenM1Next;
        offQ   <= '0;
      end else if (ctrl.issue) begin
        offQ <= segEnd ? '0 : offQ + ADDR_W'(1);
      end
    end
  end

  assign sampleValid = rdPendQ;
  assign sampleOut   = rdPendQ ? memData : heldQ;

  // R4
  offset_in_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    offQ <= lenM1Q);

  // R5
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPendQ |-> $past(ctrl.issue));

  // R6
  hold_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdPendQ && !$past(rdPendQ)) |-> $stable(sampleOut));

endmodule

// File: rtl/loop_wave_seq.sv
module loop_wave_seq
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int REP_W  = 16,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic [REP_W-1:0]  repeatCnt,
  input  logic              trigIn,
  input  logic              tick,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              busy,
  output logic              done
);

  dpCtrl_t ctrl;
  logic    segEnd;

  wseq_ctrl #(.REP_W(REP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .repeatCnt(repeatCnt), .trigIn(trigIn), .tick(tick),
    .segEnd(segEnd), .ctrl(ctrl), .busy(busy), .done(done)
  );

  wseq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startAddr(startAddr),
    .segLen(segLen), .memData(memData), .memAddr(memAddr),
    .memRdEn(memRdEn), .segEnd(segEnd), .sampleOut(sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/tb_loop_wave_seq.sv
module tb_loop_wave_seq;
  localparam int AW = 13, DW = 16, RW = 16, LW = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, enable, trigIn, tick;
  logic [1:0]    mode;
  logic [AW-1:0] startAddr, memAddr;
  logic [LW-1:0] segLen;
  logic [RW-1:0] repeatCnt;
  logic          memRdEn, sampleValid, busy, done;
  logic [DW-1:0] memData, sampleOut;

  int checks = 0, fails = 0;
  string curReq = "R2";
  logic [DW-1:0] expQ[$];

  loop_wave_seq dut (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .startAddr(startAddr), .segLen(segLen), .repeatCnt(repeatCnt),
    .trigIn(trigIn), .tick(tick), .memAddr(memAddr), .memRdEn(memRdEn),
    .memData(memData), .sampleOut(sampleOut), .sampleValid(sampleValid),
    .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {3'b000, a} ^ 16'h5A3C;
  endfunction

  // memory model with one cycle of read latency
  always @(posedge clk) if (memRdEn) memData <= pat(memAddr);

  // update tick: one cycle high out of every four
  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected sample actual=%h expected=none", curReq, sampleOut);
      end else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        if (sampleOut !== e) begin
          fails++;
          $display("FAIL %s: sample actual=%h expected=%h", curReq, sampleOut, e);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushSeg(input logic [AW-1:0] st, input int len, input int passes);
    for (int p = 0; p < passes; p++)
      for (int k = 0; k < len; k++) expQ.push_back(pat(st + AW'(k)));
  endtask

  task automatic pulseTrig();
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk) trigIn = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; trigIn = 1'b0; mode = 2'd0;
    startAddr = '0; segLen = '0; repeatCnt = '0;
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, memRdEn, sampleValid}, 4'b0000);
    rstN = 1'b1; enable = 1'b1;
    repeat (2) @(negedge clk);

    // R2 burst with three passes, R7 retrigger ignored
    curReq = "R2"; mode = 2'd1; startAddr = 13'd10; segLen = 14'd4; repeatCnt = 16'd3;
    pushSeg(13'd10, 4, 3);
    pulseTrig();
    repeat (8) @(negedge clk);
    curReq = "R7";
    pulseTrig();
    waitDone();
    chk("R6", {busy, done}, 2'b01);
    repeat (12) @(negedge clk);
    chk("R6", {sampleValid, sampleOut}, {1'b0, pat(13'd13)});
    chk("R7", expQ.size(), 0);

    // R3 repeat 0 as one pass, R4 wrap, R6 done clears on new trigger
    curReq = "R4"; mode = 2'd2; startAddr = 13'd8190; segLen = 14'd5; repeatCnt = 16'd0;
    pushSeg(13'd8190, 5, 1);
    pulseTrig();
    chk("R6", {busy, done}, 2'b10);
    waitDone();
    repeat (4) @(negedge clk);
    chk("R3", expQ.size(), 0);

    // R3 zero length plays one sample per pass
    curReq = "R3"; mode = 2'd1; startAddr = 13'd7; segLen = 14'd0; repeatCnt = 16'd2;
    pushSeg(13'd7, 1, 2);
    pulseTrig();
    waitDone();
    repeat (4) @(negedge clk);
    chk("R3", expQ.size(), 0);

    // R3 oversize length clamps to the full buffer, R4 whole-buffer wrap
    curReq = "R3"; mode = 2'd2; startAddr = 13'd100; segLen = 14'd9000; repeatCnt = 16'd1;
    pushSeg(13'd100, 8192, 1);
    pulseTrig();
    waitDone();
    repeat (4) @(negedge clk);
    chk("R4", expQ.size(), 0);

    // R10 disable clears done and ignores triggers
    enable = 1'b0;
    @(negedge clk);
    chk("R10", {busy, done}, 2'b00);
    curReq = "R10"; mode = 2'd1;
    pulseTrig();
    repeat (10) @(negedge clk);
    chk("R10", {busy, memRdEn}, 2'b00);

    // R8 continuous loops past the repeat count without done
    enable = 1'b1;
    curReq = "R8"; mode = 2'd3; startAddr = 13'd100; segLen = 14'd3; repeatCnt = 16'd1;
    pushSeg(13'd100, 3, 4);
    pulseTrig();
    while (expQ.size() != 0) @(negedge clk);
    chk("R8", {busy, done}, 2'b10);
    enable = 1'b0;
    @(negedge clk);
    chk("R10", {busy, done}, 2'b00);
    repeat (10) @(negedge clk);

    // R9 single step, wrapping within a two-sample segment
    enable = 1'b1;
    curReq = "R9"; mode = 2'd0; startAddr = 13'd50; segLen = 14'd2; repeatCnt = 16'd5;
    for (int i = 0; i < 3; i++) begin
      expQ.push_back(pat(13'd50 + AW'(i % 2)));
      pulseTrig();
      repeat (8) @(negedge clk);
      chk("R9", expQ.size(), 0);
      chk("R9", {busy, done}, 2'b10);
    end
    enable = 1'b0;
    @(negedge clk);
    chk("R10", busy, 1'b0);

    repeat (10) @(negedge clk);
    chk("R5", expQ.size(), 0);
    summary();
  end

endmodule